// File: doc/BRIEF.md
# Attribute Memory Card Information Responder

This block answers the attribute-memory space of a 16-bit PC Card. When the host selects the card with the low chip enable and the register-space strobe, a read returns one byte of the card information structure or the configuration option register on the low data byte. A write to the configuration option register moves the card from memory-only behaviour into memory-or-I/O behaviour, which the block reports on an enable flag that gates the card's I/O channel.

The card information bytes come from a parameter table. Byte n of the table sits at attribute address 2n. Reads of odd addresses, and of locations that are neither a table entry nor the register, return 0xFF. The host pins are expected to be synchronised to `clk` before they reach the block. Read data is registered, so it appears one cycle after the strobe is seen.

Top module: `attr_mem_cis`

## Requirements
- R1: In a cycle where `ce1_n`=0, `reg_n`=0, `oe_n`=0 and `we_n`=1 with an even address 2n, where n is below the table length, `rdata` in the next cycle carries table byte n. The default 18-byte table is, from n=0: 01 03 00 00 FF 1A 05 01 01 00 02 01 1B 03 C1 01 00 FF. In that table, the configuration tuple gives register base 0x200 and mask 0x01, and the single entry has index 1 with the memory-or-I/O interface and no wait states.
- R2: A read at any odd attribute address returns 0xFF.
- R3: A read at an even address that is beyond the table and is not 0x200 returns 0xFF. The table's last byte (address 34 by default) reads 0xFF, which is the end-of-chain marker.
- R4: `rdata_oe` is 1 in the cycle after a read strobe and is 0 in every other case, including when `ce1_n`, `reg_n` or `oe_n` is high.
- R5: A read at 0x200 returns the last value written to the configuration option register, with bit 7 as 0.
- R6: A write strobe (`ce1_n`=0, `reg_n`=0, `we_n`=0, `oe_n`=1) at 0x200 stores `wdata[6:0]`. From the next cycle, `io_enable` is 1 exactly when the stored index bits [5:0] are non-zero, so writing zero returns the card to memory-only mode.
- R7: A write at 0x200 with `wdata[7]`=1 clears the whole register and drops `io_enable`.
- R8: Writes to any attribute address other than 0x200 leave the register and `io_enable` unchanged.
- R9: A write with `reg_n` high (common memory) or with `ce1_n` high leaves the register and `io_enable` unchanged.
- R10: While `rst` is high at a clock edge, the register is cleared, `io_enable` is 0 and `rdata_oe` is 0. Reset wins over a write in the same cycle.
- R11: A write strobe held low for several cycles commits only once, in its first cycle. Data that changes later in the same strobe is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ce1_n | input | 1 | Low-byte card enable, active low |
| reg_n | input | 1 | Attribute-space select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W (12) | Host address |
| wdata | input | 8 | Host write data, low byte |
| rdata | output | 8 | Read data for the low byte |
| rdata_oe | output | 1 | Drive enable for the low data byte |
| io_enable | output | 1 | Memory-or-I/O mode active |

## Verification
A register write commit and a register read can fall on consecutive edges. The bench issues a single-cycle write to 0x200 and follows it at once with a read of 0x200, and it expects the new value from the very first read cycle. A synchronous reset can also arrive in the same cycle as a write strobe. The bench raises `rst` while a non-zero index is being written and expects `io_enable` to stay 0. In both cases the behavioural model, which is updated edge by edge, is compared with the outputs on every clock.

// File: rtl/attr_pkg.sv
package attr_pkg;

    typedef logic [7:0] byte_t;

    // state of the host-facing read path
    typedef struct packed {
        byte_t rdata;
        logic  rdrive;
        logic  wr_prev;
    } port_state_t;

    // state of the configuration option register
    typedef struct packed {
        logic [6:0] cor;
    } cfg_state_t;

    localparam int CIS_DEF_LEN = 18;
    // byte n of the table sits at bits [8n+7:8n]
    localparam logic [8*CIS_DEF_LEN-1:0] CIS_DEF_TABLE =
        144'hFF_00_01_C1_03_1B_01_02_00_01_01_05_1A_FF_00_00_03_01;

endpackage

// File: rtl/attr_decode.sv
module attr_decode (
    input  logic ce1_n,
    input  logic reg_n,
    input  logic oe_n,
    input  logic we_n,
    output logic rd_stb,
    output logic wr_stb
);
    logic attr_sel;

    always_comb begin
        attr_sel = !ce1_n && !reg_n;
        rd_stb   = attr_sel && !oe_n && we_n;
        wr_stb   = attr_sel && !we_n && oe_n;
    end
endmodule

// File: rtl/attr_cis_rom.sv
module attr_cis_rom #(
    parameter int                     CIS_LEN   = attr_pkg::CIS_DEF_LEN,
    parameter logic [8*CIS_LEN-1:0]   CIS_TABLE = attr_pkg::CIS_DEF_TABLE,
    parameter int                     IDX_W     = 11
) (
    input  logic [IDX_W-1:0] idx,
    output logic             hit,
    output attr_pkg::byte_t  data
);
    always_comb begin
        hit  = 1'b0;
        data = 8'hFF;
        for (int i = 0; i < CIS_LEN; i++) begin
            if (idx == IDX_W'(i)) begin
                hit  = 1'b1;
                data = CIS_TABLE[i*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/attr_cfg_reg.sv
module attr_cfg_reg (
    input  logic       clk,
    input  logic       rst,
    input  logic       commit,
    input  logic [7:0] wdata,
    output logic [6:0] cor,
    output logic       io_enable
);
    import attr_pkg::*;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            if (wdata[7]) st_d.cor = '0;
            else          st_d.cor = wdata[6:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cor       = st_q.cor;
    assign io_enable = |st_q.cor[5:0];
endmodule

// File: rtl/attr_mem_cis.sv
module attr_mem_cis #(
    parameter int                    ADDR_W    = 12,
    parameter logic [ADDR_W-1:0]     CFG_ADDR  = ADDR_W'('h200),
    parameter int                    CIS_LEN   = attr_pkg::CIS_DEF_LEN,
    parameter logic [8*CIS_LEN-1:0]  CIS_TABLE = attr_pkg::CIS_DEF_TABLE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce1_n,
    input  logic              reg_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rdata_oe,
    output logic              io_enable
);
    import attr_pkg::*;

    localparam int IDX_W = ADDR_W - 1;

    logic       rd_stb, wr_stb;
    logic       cis_hit;
    byte_t      cis_byte;
    logic [6:0] cor;
    logic       commit;
    logic       cfg_hit;

    port_state_t st_d, st_q;

    attr_decode u_decode (
        .ce1_n  (ce1_n),
        .reg_n  (reg_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .rd_stb (rd_stb),
        .wr_stb (wr_stb)
    );

    attr_cis_rom #(
        .CIS_LEN   (CIS_LEN),
        .CIS_TABLE (CIS_TABLE),
        .IDX_W     (IDX_W)
    ) u_rom (
        .idx  (addr[ADDR_W-1:1]),
        .hit  (cis_hit),
        .data (cis_byte)
    );

    attr_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .wdata     (wdata),
        .cor       (cor),
        .io_enable (io_enable)
    );

    always_comb begin
        cfg_hit = (addr == CFG_ADDR);
        // one commit per strobe: only its first cycle
        commit  = wr_stb && !st_q.wr_prev && cfg_hit;

        st_d         = st_q;
        st_d.rdrive  = rd_stb;
        st_d.wr_prev = wr_stb;
        if (cfg_hit)                   st_d.rdata = {1'b0, cor};
        else if (!addr[0] && cis_hit)  st_d.rdata = cis_byte;
        else                           st_d.rdata = 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rdata    = st_q.rdata;
    assign rdata_oe = st_q.rdrive;
endmodule

// File: rtl/attr_mem_cis_chk.sv
module attr_mem_cis_chk #(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'('h200),
    parameter int                CIS_LEN  = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              ce1_n,
    input logic              reg_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic              rdata_oe,
    input logic              io_enable
);
    logic rd, wr, wr_seen;

    assign rd = !ce1_n && !reg_n && !oe_n && we_n;
    assign wr = !ce1_n && !reg_n && !we_n && oe_n;

    always_ff @(posedge clk) begin
        if (rst) wr_seen <= 1'b0;
        else     wr_seen <= wr;
    end

    AST_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        rd |=> rdata_oe);                                            // R4
    AST_QUIET_WITHOUT_READ: assert property (@(posedge clk) disable iff (rst)
        !rd |=> !rdata_oe);                                          // R4
    AST_ODD_READS_FF: assert property (@(posedge clk) disable iff (rst)
        (rd && addr[0]) |=> (rdata == 8'hFF));                       // R2
    AST_OUTSIDE_READS_FF: assert property (@(posedge clk) disable iff (rst)
        (rd && !addr[0] && addr != CFG_ADDR && 32'(addr) >= 2*CIS_LEN)
        |=> (rdata == 8'hFF));                                       // R3
    AST_COR_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == CFG_ADDR) |=> !rdata[7]);                     // R5
    AST_INDEX_ENABLES_IO: assert property (@(posedge clk) disable iff (rst)
        (wr && !wr_seen && addr == CFG_ADDR && !wdata[7] && wdata[5:0] != 0)
        |=> io_enable);                                              // R6
    AST_SOFT_RESET_DROPS_IO: assert property (@(posedge clk) disable iff (rst)
        (wr && !wr_seen && addr == CFG_ADDR && wdata[7]) |=> !io_enable); // R7
    AST_FOREIGN_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (wr && addr != CFG_ADDR) |=> $stable(io_enable));            // R8
    AST_COMMON_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (!we_n && (reg_n || ce1_n)) |=> $stable(io_enable));         // R9
    AST_HELD_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (wr && wr_seen) |=> $stable(io_enable));                     // R11
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!io_enable && !rdata_oe));                          // R10
endmodule

bind attr_mem_cis attr_mem_cis_chk #(
    .ADDR_W   (ADDR_W),
    .CFG_ADDR (CFG_ADDR),
    .CIS_LEN  (CIS_LEN)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce1_n     (ce1_n),
    .reg_n     (reg_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .rdata_oe  (rdata_oe),
    .io_enable (io_enable)
);

// File: tb/attr_mem_cis_bench.sv
`timescale 1ns/100ps
module attr_mem_cis_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce1_n = 1'b1, reg_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_oe, io_enable;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    bit    seen_edge = 0;
    string cur_req = "R10";

    // behavioural reference
    bit [7:0] cis [18];
    bit       m_drive = 0;
    bit [7:0] m_data = 0;
    bit [6:0] m_cor = 0;
    bit       m_prev = 0;

    always #2.5 clk = ~clk;

    attr_mem_cis u_attr_mem_cis (
        .clk (clk), .rst (rst), .ce1_n (ce1_n), .reg_n (reg_n),
        .oe_n (oe_n), .we_n (we_n), .addr (addr), .wdata (wdata),
        .rdata (rdata), .rdata_oe (rdata_oe), .io_enable (io_enable)
    );

    initial begin
        cis = '{8'h01, 8'h03, 8'h00, 8'h00, 8'hFF, 8'h1A, 8'h05, 8'h01, 8'h01,
                8'h00, 8'h02, 8'h01, 8'h1B, 8'h03, 8'hC1, 8'h01, 8'h00, 8'hFF};
    end

    function automatic bit [7:0] lookup(input bit [11:0] a);
        if (a == 12'h200)           return {1'b0, m_cor};
        if (a[0])                   return 8'hFF;
        if (int'(a) / 2 < 18)       return cis[int'(a) / 2];
        return 8'hFF;
    endfunction

    always @(posedge clk) begin
        bit sel, rd, wr;
        seen_edge = 1;
        if (rst) begin
            m_drive = 0; m_data = 0; m_cor = 0; m_prev = 0;
        end else begin
            sel = !ce1_n && !reg_n;
            rd  = sel && !oe_n && we_n;
            wr  = sel && !we_n && oe_n;
            m_drive = rd;
            m_data  = lookup(addr);
            if (wr && !m_prev && addr == 12'h200)
                m_cor = wdata[7] ? 7'd0 : wdata[6:0];
            m_prev = wr;
        end
    end

    always @(negedge clk) begin
        bit m_io;
        if (seen_edge) begin
            m_io = (m_cor[5:0] != 0);
            vectors++;
            if (rdata_oe !== m_drive || (m_drive && rdata !== m_data) || io_enable !== m_io) begin
                miscompares++;
                $display("FAIL %s: oe=%0b data=%02h io=%0b, expected oe=%0b data=%02h io=%0b",
                         cur_req, rdata_oe, rdata, io_enable, m_drive, m_data, m_io);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            miscompares++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        ce1_n = 1; reg_n = 1; oe_n = 1; we_n = 1;
    endtask

    task automatic rd_attr(input bit [11:0] a);
        step(); ce1_n = 0; reg_n = 0; oe_n = 0; we_n = 1; addr = a;
        step(); idle();
        step();
    endtask

    task automatic wr_attr(input bit [11:0] a, input bit [7:0] d);
        step(); ce1_n = 0; reg_n = 0; oe_n = 1; we_n = 0; addr = a; wdata = d;
        step(); idle();
        step();
    endtask

    initial begin
        repeat (3) step();
        rst = 0;

        cur_req = "R1";
        for (int n = 0; n < 18; n++) rd_attr(12'(2 * n));

        cur_req = "R2";
        rd_attr(12'h001); rd_attr(12'h003); rd_attr(12'h023); rd_attr(12'h201);

        cur_req = "R3";
        rd_attr(12'h022); rd_attr(12'h024); rd_attr(12'h064);
        rd_attr(12'h1FE); rd_attr(12'h202); rd_attr(12'hFFE);

        cur_req = "R4";
        step(); ce1_n = 1; reg_n = 0; oe_n = 0; addr = 12'h000; step(); step(); idle();
        step(); ce1_n = 0; reg_n = 1; oe_n = 0; step(); step(); idle();
        step(); ce1_n = 0; reg_n = 0; oe_n = 0; we_n = 0; step(); step(); idle();

        cur_req = "R5";
        wr_attr(12'h200, 8'h41); rd_attr(12'h200);
        cur_req = "R6";
        wr_attr(12'h200, 8'h00); rd_attr(12'h200);
        wr_attr(12'h200, 8'h03); rd_attr(12'h200);
        wr_attr(12'h200, 8'h40); rd_attr(12'h200);

        cur_req = "R7";
        wr_attr(12'h200, 8'h05);
        wr_attr(12'h200, 8'h85); rd_attr(12'h200);

        cur_req = "R8";
        wr_attr(12'h200, 8'h01);
        wr_attr(12'h202, 8'h05); wr_attr(12'h201, 8'h00); wr_attr(12'h000, 8'h00);
        rd_attr(12'h200); rd_attr(12'h000);

        cur_req = "R9";
        step(); ce1_n = 0; reg_n = 1; we_n = 0; addr = 12'h200; wdata = 8'h00; step(); idle();
        step(); ce1_n = 1; reg_n = 0; we_n = 0; wdata = 8'h80; step(); idle();
        rd_attr(12'h200);

        cur_req = "R11";
        step(); ce1_n = 0; reg_n = 0; we_n = 0; addr = 12'h200; wdata = 8'h05;
        step(); wdata = 8'h00;
        step(); wdata = 8'h88;
        step(); idle();
        rd_attr(12'h200);

        cur_req = "R5";
        step(); ce1_n = 0; reg_n = 0; we_n = 0; oe_n = 1; addr = 12'h200; wdata = 8'h0C;
        step(); we_n = 1; oe_n = 0;
        step(); idle();
        step();

        cur_req = "R10";
        step(); ce1_n = 0; reg_n = 0; we_n = 0; addr = 12'h200; wdata = 8'h02; rst = 1;
        step(); idle(); rst = 0;
        rd_attr(12'h200);
        wr_attr(12'h200, 8'h07);
        step(); rst = 1;
        step(); rst = 0;
        rd_attr(12'h200);

        repeat (2) step();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule